// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block is a small cache that sits between a processor's load/store port and a slower main memory. Memory is addressed by word. The cache keeps a few two-word blocks, and each block may live in exactly one line. That line is chosen by the middle bits of the address. A read that finds its block present is answered in the same cycle without touching memory. Any access that does not find its block first fetches the whole block from memory into the chosen line.

Writes are always carried to memory as single-word writes, and the cached copy is updated as well. Memory therefore never holds stale data, and no cached line ever has to be copied back. A flush input drops every cached line at once, for example after software has changed memory behind the cache's back.

The processor holds an access request steady until the block raises its ready output. Memory is driven through two request/acknowledge pairs: one for block reads and one for word writes.

Top module: `dmc_cache`

## Requirements
- R1: The 6-bit word address splits into tag = addr[5:3], line index = addr[2:1] and word offset = addr[0]. A block fetch presents the 5-bit block address addr[5:1] on mem_rd_addr.
- R2: After reset every line is invalid, with no memory request and no ready while the processor is idle. The first read of any address after reset misses.
- R3: A read whose line is valid and holds the address tag raises cpu_ready in the same cycle it is presented. It returns the addressed word on cpu_rdata and issues no memory request.
- R4: A read miss performs one block fetch. mem_rd_data[15:0] is word offset 0 and mem_rd_data[31:16] is word offset 1. The line takes the new tag and data and becomes valid, and the requested word is then returned with cpu_ready.
- R5: A write that hits updates the cached word and issues one word write of cpu_wdata to address cpu_addr. cpu_ready rises in the cycle memory acknowledges that write.
- R6: A write that misses first fetches the block, then merges the new word. The other word of the line keeps the memory value and later reads it as a hit.
- R7: Two addresses with the same index and different tags evict each other, so alternating reads between them miss every time.
- R8: A flush clears every valid bit in one cycle. It takes priority over an access presented in the same cycle, and cpu_ready stays low in any cycle where flush is high.
- R9: A memory read or write request stays high with a stable address (and write data) until acknowledged. A read request and a write request are never both high.
- R10: A fill or write touches only the line chosen by its index. Blocks cached in other lines keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 6 | Word address of the access |
| cpu_rd | input | 1 | Read request, held until cpu_ready |
| cpu_wr | input | 1 | Write request, held until cpu_ready |
| cpu_wdata | input | 16 | Write data |
| cpu_flush | input | 1 | Invalidate all lines |
| cpu_rdata | output | 16 | Read data, valid with cpu_ready on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_rd_req | output | 1 | Block fetch request |
| mem_rd_addr | output | 5 | Block address of the fetch |
| mem_rd_ack | input | 1 | Fetch data valid |
| mem_rd_data | input | 32 | Fetched block, offset 1 in the upper half |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_addr | output | 6 | Word write address |
| mem_wr_data | output | 16 | Word write data |
| mem_wr_ack | input | 1 | Word write accepted |

## Verification
Three sweeps over all 64 addresses are run: a read sweep from an empty cache, a write sweep with a fresh data pattern, and a second read sweep. Together they separate even-offset misses from odd-offset hits in the same block, write hits from write misses, and tag replacement across the whole address space. Each address holds a value computed from the address, so a wrong word, a wrong line or a wrong offset half shows up as a data mismatch. Directed patterns then cover the rest. Alternating reads of two colliding addresses tell collision misses apart from cross-line interference. A write miss followed by a read of its partner word checks the merge. A flush presented together with a read, and a flush between two reads of the same address, check invalidation and its priority.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped write-through cache.
// Assumes: only the control state encoding is shared between modules.
package dmc_pkg;

    // Controller states: waiting for an access, fetching a block, writing a word
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_FILL  = 2'd1,
        CS_WRITE = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/dmc_lookup.sv
// Address decode and hit compare for one direct-mapped line.
// Splits the word address into tag, index and offset. Compares the tag with
// the indexed line and picks the addressed word from the line's block.
// Assumes: block words are packed with offset w at bits [w*DATA_W +: DATA_W].
module dmc_lookup #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 1
) (
    input  logic [TAG_W+IDX_W+OFF_W-1:0]    addr,
    input  logic                            line_valid,
    input  logic [TAG_W-1:0]                line_tag,
    input  logic [(1<<OFF_W)*DATA_W-1:0]    line_block,
    output logic [TAG_W-1:0]                tag,
    output logic [IDX_W-1:0]                idx,
    output logic [OFF_W-1:0]                off,
    output logic                            hit,
    output logic [DATA_W-1:0]               word
);

    localparam int unsigned ADDR_W = TAG_W + IDX_W + OFF_W;

    // Field extraction: tag on top, index in the middle, offset at the bottom
    always_comb begin
        tag = addr[ADDR_W-1 -: TAG_W];
        idx = addr[OFF_W +: IDX_W];
        off = addr[OFF_W-1:0];
    end

    // Hit needs both a valid line and a matching tag
    always_comb begin
        hit = line_valid && (line_tag == tag);
    end

    // Word select within the block by offset
    always_comb begin
        word = line_block[off*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/dmc_store.sv
// Tag, valid and data storage for the direct-mapped lines.
// One read port by index. A whole-block fill port. A single-word write port.
// Flush clears every valid bit and overrides a fill in the same cycle.
// Assumes: fill and word write never address the store in the same cycle.
module dmc_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic                            rd_valid,
    output logic [TAG_W-1:0]                rd_tag,
    output logic [(1<<OFF_W)*DATA_W-1:0]    rd_block,
    input  logic                            fill_en,
    input  logic [IDX_W-1:0]                fill_idx,
    input  logic [TAG_W-1:0]                fill_tag,
    input  logic [(1<<OFF_W)*DATA_W-1:0]    fill_block,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [OFF_W-1:0]                wr_off,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [(1<<IDX_W)-1:0]           valid_vec
);

    localparam int unsigned LINES = 1 << IDX_W;
    localparam int unsigned WORDS = 1 << OFF_W;
    localparam int unsigned BLK_W = WORDS * DATA_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [BLK_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel_fill;
        logic sel_wr;

        // Line selection for the two write ports
        always_comb begin
            sel_fill = fill_en && (fill_idx == IDX_W'(g));
            sel_wr   = wr_en && (wr_idx == IDX_W'(g));
        end

        // Valid bit: cleared by reset and flush, set by a fill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (flush) begin
                valid_q[g] <= 1'b0;
            end else if (sel_fill) begin
                valid_q[g] <= 1'b1;
            end
        end

        // Tag: loaded on fill only
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g] <= '0;
            end else if (sel_fill) begin
                tag_q[g] <= fill_tag;
            end
        end

        // Data: whole block on fill, one word on a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
            end else if (sel_fill) begin
                data_q[g] <= fill_block;
            end else if (sel_wr) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (wr_off == OFF_W'(w)) begin
                        data_q[g][w*DATA_W +: DATA_W] <= wr_data;
                    end
                end
            end
        end
    end

    // Indexed read port
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_block = data_q[rd_idx];
    end

    // Valid bits for observation
    always_comb begin
        valid_vec = valid_q;
    end

endmodule

// File: rtl/dmc_ctrl.sv
// Access controller for the write-through cache.
// Read hit: completes at once. Any miss: fetch the block, then re-evaluate.
// Write hit: word write to memory, updating the cache when memory acknowledges.
// Flush in the idle state blocks the access for that cycle.
// Assumes: the processor holds address, data and request until ready.
module dmc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic acc_rd,
    input  logic acc_wr,
    input  logic hit,
    input  logic mem_rd_ack,
    input  logic mem_wr_ack,
    output logic mem_rd_req,
    output logic mem_wr_req,
    output logic fill_en,
    output logic word_wr_en,
    output logic cpu_ready
);

    import dmc_pkg::*;

    ctrl_state_t state_q;
    ctrl_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (!flush && acc_wr) begin
                    state_d = hit ? CS_WRITE : CS_FILL;
                end else if (!flush && acc_rd && !hit) begin
                    state_d = CS_FILL;
                end
            end
            CS_FILL: begin
                if (mem_rd_ack) state_d = CS_IDLE;
            end
            CS_WRITE: begin
                if (mem_wr_ack) state_d = CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Memory requests, store strobes and processor handshake
    always_comb begin
        mem_rd_req = (state_q == CS_FILL);
        mem_wr_req = (state_q == CS_WRITE);
        fill_en    = (state_q == CS_FILL) && mem_rd_ack;
        word_wr_en = (state_q == CS_WRITE) && mem_wr_ack;
        cpu_ready  = ((state_q == CS_IDLE) && !flush && acc_rd && !acc_wr && hit)
                  || ((state_q == CS_WRITE) && mem_wr_ack && !flush);
    end

endmodule

// File: rtl/dmc_cache.sv
// Top of the direct-mapped write-through cache.
// Joins lookup, storage and controller. Exposes the processor port and the
// two memory channels (block read, word write).
// Assumes: cpu_rd and cpu_wr are not raised together; a write wins if they are.
module dmc_cache #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]        cpu_addr,
    input  logic                                cpu_rd,
    input  logic                                cpu_wr,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    input  logic                                cpu_flush,
    output logic [DATA_W-1:0]                   cpu_rdata,
    output logic                                cpu_ready,
    output logic                                mem_rd_req,
    output logic [TAG_W+IDX_W-1:0]              mem_rd_addr,
    input  logic                                mem_rd_ack,
    input  logic [(1<<OFF_W)*DATA_W-1:0]        mem_rd_data,
    output logic                                mem_wr_req,
    output logic [TAG_W+IDX_W+OFF_W-1:0]        mem_wr_addr,
    output logic [DATA_W-1:0]                   mem_wr_data,
    input  logic                                mem_wr_ack
);

    localparam int unsigned LINES = 1 << IDX_W;
    localparam int unsigned BLK_W = (1 << OFF_W) * DATA_W;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [BLK_W-1:0]  line_block;
    logic              hit;
    logic [DATA_W-1:0] hit_word;
    logic              fill_en;
    logic              word_wr_en;
    logic [LINES-1:0]  valid_vec;

    dmc_lookup #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_lookup (
        .addr       (cpu_addr),
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .line_block (line_block),
        .tag        (a_tag),
        .idx        (a_idx),
        .off        (a_off),
        .hit        (hit),
        .word       (hit_word)
    );

    dmc_store #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (cpu_flush),
        .rd_idx     (a_idx),
        .rd_valid   (line_valid),
        .rd_tag     (line_tag),
        .rd_block   (line_block),
        .fill_en    (fill_en),
        .fill_idx   (a_idx),
        .fill_tag   (a_tag),
        .fill_block (mem_rd_data),
        .wr_en      (word_wr_en),
        .wr_idx     (a_idx),
        .wr_off     (a_off),
        .wr_data    (cpu_wdata),
        .valid_vec  (valid_vec)
    );

    dmc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (cpu_flush),
        .acc_rd     (cpu_rd),
        .acc_wr     (cpu_wr),
        .hit        (hit),
        .mem_rd_ack (mem_rd_ack),
        .mem_wr_ack (mem_wr_ack),
        .mem_rd_req (mem_rd_req),
        .mem_wr_req (mem_wr_req),
        .fill_en    (fill_en),
        .word_wr_en (word_wr_en),
        .cpu_ready  (cpu_ready)
    );

    // Memory-side addresses and data come straight from the held access
    always_comb begin
        mem_rd_addr = {a_tag, a_idx};
        mem_wr_addr = cpu_addr;
        mem_wr_data = cpu_wdata;
        cpu_rdata   = hit_word;
    end

endmodule

// File: rtl/dmc_cache_chk.sv
// Protocol and state checker for dmc_cache, attached by bind.
// Assumes: it sees the top ports plus the valid-bit vector.
module dmc_cache_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cpu_rd,
    input logic                          cpu_wr,
    input logic                          cpu_flush,
    input logic                          cpu_ready,
    input logic                          mem_rd_req,
    input logic [TAG_W+IDX_W-1:0]        mem_rd_addr,
    input logic                          mem_rd_ack,
    input logic                          mem_wr_req,
    input logic [TAG_W+IDX_W+OFF_W-1:0]  mem_wr_addr,
    input logic [DATA_W-1:0]             mem_wr_data,
    input logic                          mem_wr_ack,
    input logic [(1<<IDX_W)-1:0]         valid_vec
);

    AST_RD_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_ready) |-> (!mem_rd_req && !mem_wr_req)); // R3

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack && !cpu_flush) |=> valid_vec[$past(mem_rd_addr[IDX_W-1:0])]); // R4

    AST_WR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_ready) |-> (mem_wr_req && mem_wr_ack)); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_flush |=> (valid_vec == '0)); // R8

    AST_FLUSH_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_flush |-> !cpu_ready); // R8

    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R9

    AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R9

    AST_WR_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R9

endmodule

bind dmc_cache dmc_cache_chk #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .cpu_flush   (cpu_flush),
    .cpu_ready   (cpu_ready),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_ack  (mem_wr_ack),
    .valid_vec   (valid_vec)
);

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps
// Self-checking bench for dmc_cache: address sweeps plus directed cases,
// with a behavioural memory and a bench-side tag/valid reference.
module test_dmc_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_flush = 1'b0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_rd_req;
    logic [4:0]  mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [5:0]  mem_wr_addr;
    logic [15:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int fills = 0;
    int wcount = 0;
    int lat = 0;
    logic [4:0]  last_rd_addr = '0;
    logic [15:0] bmem    [64];
    logic [15:0] exp_mem [64];
    logic        r_valid [4];
    logic [2:0]  r_tag   [4];

    always #2 clk = ~clk;  // 250 MHz

    dmc_cache i_dmc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_flush(cpu_flush),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack)
    );

    // Behavioural memory: block read after two cycles, word write in one
    always @(negedge clk) begin
        if (mem_rd_req && !mem_rd_ack) begin
            lat++;
            if (lat >= 2) begin
                mem_rd_data  = {bmem[{mem_rd_addr, 1'b1}], bmem[{mem_rd_addr, 1'b0}]};
                mem_rd_ack   = 1'b1;
                last_rd_addr = mem_rd_addr;
                lat = 0;
                fills++;
            end
        end else begin
            mem_rd_ack = 1'b0;
        end
        if (mem_wr_req && !mem_wr_ack) begin
            bmem[mem_wr_addr] = mem_wr_data;
            mem_wr_ack = 1'b1;
            wcount++;
        end else begin
            mem_wr_ack = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(input string tag, output int cyc);
        cyc = 0;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1;
            cyc++;
        end
        if (!cpu_ready) chk({tag, " ready timeout"}, 32'd0, 32'd1);
    endtask

    task automatic ref_clear();
        for (int i = 0; i < 4; i++) r_valid[i] = 1'b0;
    endtask

    // One read; expected hit from the reference, data from the expected memory
    task automatic do_read(input logic [5:0] a, output logic was_hit);
        int f0 = fills;
        int cyc;
        logic [1:0] ix = a[2:1];
        logic [15:0] got;
        was_hit = r_valid[ix] && (r_tag[ix] == a[5:3]);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        wait_ready(was_hit ? "R3" : "R4", cyc);
        got = cpu_rdata;
        @(posedge clk); #1;
        cpu_rd = 1'b0;
        if (was_hit) begin
            chk("R3 hit data", 32'(got), 32'(exp_mem[a]));
            chk("R3 hit no fetch, no stall", 32'((fills - f0) + cyc), 32'd0);
        end else begin
            chk("R4 miss data", 32'(got), 32'(exp_mem[a]));
            chk("R4 one fetch", 32'(fills - f0), 32'd1);
            chk("R1 block address", 32'(last_rd_addr), 32'(a[5:1]));
        end
        r_valid[ix] = 1'b1;
        r_tag[ix] = a[5:3];
    endtask

    // One write; checks write-through and fill-before-merge on a miss
    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        int f0 = fills;
        int w0 = wcount;
        int cyc;
        logic [1:0] ix = a[2:1];
        logic hit_e = r_valid[ix] && (r_tag[ix] == a[5:3]);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = d;
        #1;
        wait_ready("R5", cyc);
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        exp_mem[a] = d;
        chk("R5 one word write", 32'(wcount - w0), 32'd1);
        chk("R5 memory word", 32'(bmem[a]), 32'(d));
        if (hit_e) chk("R5 write hit no fetch", 32'(fills - f0), 32'd0);
        else       chk("R6 write miss fetch", 32'(fills - f0), 32'd1);
        r_valid[ix] = 1'b1;
        r_tag[ix] = a[5:3];
    endtask

    task automatic do_flush();
        @(negedge clk);
        cpu_flush = 1'b1;
        @(posedge clk); #1;
        cpu_flush = 1'b0;
        ref_clear();
    endtask

    // Watchdog
    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic h;
        int f0;
        for (int a = 0; a < 64; a++) begin
            bmem[a] = 16'((a * 613 + 4242) & 16'hffff);
            exp_mem[a] = bmem[a];
        end
        ref_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R2 ready idle", 32'(cpu_ready), 32'd0);
        chk("R2 no read req", 32'(mem_rd_req), 32'd0);
        chk("R2 no write req", 32'(mem_wr_req), 32'd0);

        // Read sweep from empty: even offsets miss, odd partners hit
        for (int a = 0; a < 64; a++) begin
            do_read(6'(a), h);
            if (a == 0) chk("R2 first read misses", 32'(h), 32'd0);
        end
        // Write sweep with a new pattern
        for (int a = 0; a < 64; a++) do_write(6'(a), 16'(16'hA5C3 ^ (a * 257)));
        // Second read sweep
        for (int a = 63; a >= 0; a--) do_read(6'(a), h);

        // R10: fills in lines 0 and 1 leave each other intact
        do_flush();
        do_read(6'h00, h);
        do_read(6'h02, h);
        f0 = fills;
        do_read(6'h01, h);
        chk("R10 other line kept", 32'(fills - f0), 32'd0);

        // R7: colliding addresses alternate with a miss each time
        do_flush();
        f0 = fills;
        for (int k = 0; k < 4; k++) begin
            do_read(6'h04, h);
            do_read(6'h0C, h);
        end
        chk("R7 collision misses", 32'(fills - f0), 32'd8);

        // R6: write miss merges and keeps the partner word from memory
        do_flush();
        do_write(6'h15, 16'h1234);
        f0 = fills;
        do_read(6'h14, h);
        chk("R6 partner word hit", 32'(fills - f0), 32'd0);
        do_read(6'h15, h);
        chk("R6 merged word hit", 32'(h), 32'd1);

        // R8: flush with a read of a cached address, then the read misses
        do_read(6'h15, h);
        @(negedge clk);
        cpu_addr = 6'h15; cpu_rd = 1'b1; cpu_flush = 1'b1;
        #1;
        chk("R8 flush blocks ready", 32'(cpu_ready), 32'd0);
        @(posedge clk); #1;
        cpu_flush = 1'b0; cpu_rd = 1'b0;
        ref_clear();
        f0 = fills;
        do_read(6'h15, h);
        chk("R8 miss after flush", 32'(fills - f0), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule